// File: doc/BRIEF.md
# Asymmetric Dual-Port Bit-Array RAM

This block is a 4096-bit synchronous RAM with two fully independent ports, A and B. Each port has its own clock, enable, write enable, output-register clear, address, write data and registered read data. The data width of each port is fixed at elaboration to 1, 2, 4, 8 or 16 bits. The two widths may differ, and both ports then see the same bit array through a fixed bit-level mapping. A port can therefore write bytes while the other reads pairs of bits, for example.

A write is write-first: the written word also appears on that port's read data after the edge. A disabled port neither writes nor changes its output. The clear input only zeroes the output register and never touches the stored bits. Each of the four control inputs of each port, including the clock, can be inverted by a parameter.

Simultaneous writes by both ports to overlapping bits give an undefined stored value. The block does not arbitrate such writes.

The control and data pins are plain synchronous pins with no valid/ready handshake. Each port accepts one command on every active edge of its own clock and never applies back-pressure. A command is qualified only by that port's enable.

Top module: `asym_dpram`

## Requirements
- R1: The array holds 4096 bits. A port word of width W at address N covers physical bits N*W (word bit 0) up to N*W+W-1 (word bit W-1), so both ports read and write the same cells.
- R2: Each port's width is a parameter from {1,2,4,8,16}, giving address widths of 12, 11, 10, 9 and 8 bits. The top address of each port reaches the last bit of the array.
- R3: On an active edge with enable active and write enable and clear inactive, read data shows the addressed word as stored before that edge.
- R4: On an active edge with enable and write enable active, the input word is stored at the address. Read data after the edge equals the input word (write-first).
- R5: On an edge with enable inactive, the port stores nothing and its read data keeps its previous value.
- R6: On an edge with enable and clear active, read data becomes zero and the stored bits are unchanged. Clear with enable inactive has no effect.
- R7: When clear and write are both active on an enabled edge, the write is stored and read data becomes zero.
- R8: Each of clock, enable, write enable and clear on each port has its own inversion parameter. An inverted control is active low, and an inverted clock makes the falling edge active.
- R9: The ports run on unrelated clocks. A word written through one port is read back through the other after the write edge, provided the accesses do not overlap.
- R10: Stored bits and both read-data registers are zero at time zero.
- R11: A clear or read on one port does not disturb a write that the other port performs at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock (edge set by INV_CLK_A) |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A read-data clear |
| addr_a | input | log2(4096/WIDTH_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock (edge set by INV_CLK_B) |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B read-data clear |
| addr_b | input | log2(4096/WIDTH_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
The bench builds the block with WIDTH_A = 8 and WIDTH_B = 2. This mixed pair exposes the bit mapping: each byte written on one side splits into four two-bit words on the other, and the reverse. All four of port B's inversion parameters are set, so port B runs on the falling edge of its clock with active-low controls, while port A keeps the plain polarity. The two clocks have unrelated periods, and the run includes a phase where both ports operate concurrently on disjoint regions.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int ARRAY_BITS = 4096;
  localparam int BIT_IDX_W  = $clog2(ARRAY_BITS);

  function automatic int word_addr_bits(input int width);
    return $clog2(ARRAY_BITS / width);
  endfunction
endpackage

// File: rtl/adp_pin_pol.sv
module adp_pin_pol #(
  parameter bit INVERT = 1'b0
) (
  input  logic pin_in,
  output logic pin_out
);
  generate
    if (INVERT) begin : g_inv
      assign pin_out = ~pin_in;
    end else begin : g_pass
      assign pin_out = pin_in;
    end
  endgenerate
endmodule

// File: rtl/adp_port.sv
// One port of the shared array. Each port owns a private bank that only it
// writes; the stored value of a bit is the XOR of both banks.
module adp_port #(
  parameter int WIDTH   = 8,
  parameter bit INV_CLK = 1'b0,
  parameter bit INV_EN  = 1'b0,
  parameter bit INV_WE  = 1'b0,
  parameter bit INV_RST = 1'b0,
  localparam int BITS   = adp_pkg::ARRAY_BITS,
  localparam int BW     = adp_pkg::BIT_IDX_W,
  localparam int AW     = adp_pkg::word_addr_bits(WIDTH),
  localparam int LOGW   = $clog2(WIDTH)
) (
  input  logic             clk_pin,
  input  logic             en_pin,
  input  logic             we_pin,
  input  logic             rst_pin,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] din,
  input  logic [BITS-1:0]  peer_bank,
  output logic [BITS-1:0]  own_bank,
  output logic [WIDTH-1:0] dout
);
  logic clk_act, en_act, we_act, rst_act;

  adp_pin_pol #(.INVERT(INV_CLK)) u_pol_clk (.pin_in(clk_pin), .pin_out(clk_act));
  adp_pin_pol #(.INVERT(INV_EN))  u_pol_en  (.pin_in(en_pin),  .pin_out(en_act));
  adp_pin_pol #(.INVERT(INV_WE))  u_pol_we  (.pin_in(we_pin),  .pin_out(we_act));
  adp_pin_pol #(.INVERT(INV_RST)) u_pol_rst (.pin_in(rst_pin), .pin_out(rst_act));

  logic [BITS-1:0]  bank_q = '0;
  logic [WIDTH-1:0] dout_q = '0;
  logic [BW-1:0]    base;
  logic [WIDTH-1:0] word_now;

  assign base     = BW'(addr) << LOGW;
  assign word_now = bank_q[base +: WIDTH] ^ peer_bank[base +: WIDTH];

  always_ff @(posedge clk_act) begin
    if (en_act) begin
      if (we_act) begin
        bank_q[base +: WIDTH] <= din ^ peer_bank[base +: WIDTH];
      end
      if (rst_act) begin
        dout_q <= '0;
      end else if (we_act) begin
        dout_q <= din;
      end else begin
        dout_q <= word_now;
      end
    end
  end

  assign own_bank = bank_q;
  assign dout     = dout_q;
endmodule

// File: rtl/asym_dpram.sv
module asym_dpram #(
  parameter int WIDTH_A   = 8,
  parameter int WIDTH_B   = 2,
  parameter bit INV_CLK_A = 1'b0,
  parameter bit INV_EN_A  = 1'b0,
  parameter bit INV_WE_A  = 1'b0,
  parameter bit INV_RST_A = 1'b0,
  parameter bit INV_CLK_B = 1'b0,
  parameter bit INV_EN_B  = 1'b0,
  parameter bit INV_WE_B  = 1'b0,
  parameter bit INV_RST_B = 1'b0,
  localparam int AW_A     = adp_pkg::word_addr_bits(WIDTH_A),
  localparam int AW_B     = adp_pkg::word_addr_bits(WIDTH_B),
  localparam int BITS     = adp_pkg::ARRAY_BITS
) (
  input  logic               clk_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic               rst_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               clk_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic               rst_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] dout_b
);
  logic [BITS-1:0] bank_a, bank_b;

  adp_port #(
    .WIDTH(WIDTH_A), .INV_CLK(INV_CLK_A), .INV_EN(INV_EN_A),
    .INV_WE(INV_WE_A), .INV_RST(INV_RST_A)
  ) u_port_a (
    .clk_pin(clk_a), .en_pin(en_a), .we_pin(we_a), .rst_pin(rst_a),
    .addr(addr_a), .din(din_a), .peer_bank(bank_b), .own_bank(bank_a),
    .dout(dout_a)
  );

  adp_port #(
    .WIDTH(WIDTH_B), .INV_CLK(INV_CLK_B), .INV_EN(INV_EN_B),
    .INV_WE(INV_WE_B), .INV_RST(INV_RST_B)
  ) u_port_b (
    .clk_pin(clk_b), .en_pin(en_b), .we_pin(we_b), .rst_pin(rst_b),
    .addr(addr_b), .din(din_b), .peer_bank(bank_a), .own_bank(bank_b),
    .dout(dout_b)
  );
endmodule

// File: rtl/adp_checker.sv
module adp_checker #(
  parameter int WIDTH_A   = 8,
  parameter int WIDTH_B   = 2,
  parameter bit INV_CLK_A = 1'b0,
  parameter bit INV_EN_A  = 1'b0,
  parameter bit INV_WE_A  = 1'b0,
  parameter bit INV_RST_A = 1'b0,
  parameter bit INV_CLK_B = 1'b0,
  parameter bit INV_EN_B  = 1'b0,
  parameter bit INV_WE_B  = 1'b0,
  parameter bit INV_RST_B = 1'b0
) (
  input logic               clk_a,
  input logic               en_a,
  input logic               we_a,
  input logic               rst_a,
  input logic [WIDTH_A-1:0] din_a,
  input logic [WIDTH_A-1:0] dout_a,
  input logic               clk_b,
  input logic               en_b,
  input logic               we_b,
  input logic               rst_b,
  input logic [WIDTH_B-1:0] din_b,
  input logic [WIDTH_B-1:0] dout_b
);
  logic ck_a, ck_b, ea, wa, ra, eb, wb, rb;
  assign ck_a = clk_a ^ INV_CLK_A;
  assign ea   = en_a  ^ INV_EN_A;
  assign wa   = we_a  ^ INV_WE_A;
  assign ra   = rst_a ^ INV_RST_A;
  assign ck_b = clk_b ^ INV_CLK_B;
  assign eb   = en_b  ^ INV_EN_B;
  assign wb   = we_b  ^ INV_WE_B;
  assign rb   = rst_b ^ INV_RST_B;

  logic armed_a = 1'b0;
  logic armed_b = 1'b0;
  always_ff @(posedge ck_a) armed_a <= 1'b1;
  always_ff @(posedge ck_b) armed_b <= 1'b1;

  p_hold_disabled_a_r5: assert property (@(posedge ck_a) disable iff (!armed_a)
    !ea |=> $stable(dout_a));
  p_clear_out_a_r6: assert property (@(posedge ck_a) disable iff (!armed_a)
    (ea && ra) |=> (dout_a == '0));
  p_write_first_a_r4: assert property (@(posedge ck_a) disable iff (!armed_a)
    (ea && wa && !ra) |=> (dout_a == $past(din_a)));
  p_hold_disabled_b_r5: assert property (@(posedge ck_b) disable iff (!armed_b)
    !eb |=> $stable(dout_b));
  p_clear_out_b_r6: assert property (@(posedge ck_b) disable iff (!armed_b)
    (eb && rb) |=> (dout_b == '0));
  p_write_first_b_r4: assert property (@(posedge ck_b) disable iff (!armed_b)
    (eb && wb && !rb) |=> (dout_b == $past(din_b)));
endmodule

bind asym_dpram adp_checker #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B),
  .INV_CLK_A(INV_CLK_A), .INV_EN_A(INV_EN_A), .INV_WE_A(INV_WE_A), .INV_RST_A(INV_RST_A),
  .INV_CLK_B(INV_CLK_B), .INV_EN_B(INV_EN_B), .INV_WE_B(INV_WE_B), .INV_RST_B(INV_RST_B)
) u_adp_checker (
  .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .rst_a(rst_a), .din_a(din_a), .dout_a(dout_a),
  .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .rst_b(rst_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/test_asym_dpram.sv
module test_asym_dpram;
  localparam int CLK_PERIOD   = 10;
  localparam int CLK_PERIOD_B = 14;
  localparam int WA  = 8;
  localparam int WB  = 2;
  localparam int AWA = 9;
  localparam int AWB = 11;

  logic clk_a = 1'b0, clk_b = 1'b0;
  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_PERIOD_B/2) clk_b = ~clk_b;

  logic en_a = 1'b0, we_a = 1'b0, rst_a = 1'b0;
  logic [AWA-1:0] addr_a = '0;
  logic [WA-1:0]  din_a = '0;
  logic [WA-1:0]  dout_a;
  // Port B controls are inverted: idle level is high.
  logic en_b = 1'b1, we_b = 1'b1, rst_b = 1'b1;
  logic [AWB-1:0] addr_b = '0;
  logic [WB-1:0]  din_b = '0;
  logic [WB-1:0]  dout_b;

  asym_dpram #(
    .WIDTH_A(WA), .WIDTH_B(WB),
    .INV_CLK_B(1'b1), .INV_EN_B(1'b1), .INV_WE_B(1'b1), .INV_RST_B(1'b1)
  ) i_asym_dpram (
    .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .rst_a(rst_a),
    .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .rst_b(rst_b),
    .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
  );

  int checks = 0;
  int errors = 0;
  logic [4095:0] mdl = '0;
  logic [WA-1:0] hold_a = '0;
  logic [WB-1:0] hold_b = '0;
  logic [WA-1:0] qa_val[$];
  string         qa_tag[$];
  logic [WB-1:0] qb_val[$];
  string         qb_tag[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver for port A: active edge is the rising edge, controls active high.
  task automatic op_a(input logic en, input logic we, input logic rst,
                      input logic [AWA-1:0] ad, input logic [WA-1:0] d, input string tag);
    @(negedge clk_a);
    en_a = en; we_a = we; rst_a = rst; addr_a = ad; din_a = d;
    @(posedge clk_a);
    #1;
    if (en) begin
      if (rst) hold_a = '0;
      else if (we) hold_a = d;
      else hold_a = mdl[ad*WA +: WA];
      if (we) mdl[ad*WA +: WA] = d;
    end
    qa_val.push_back(hold_a);
    qa_tag.push_back(tag);
    en_a = 1'b0; we_a = 1'b0; rst_a = 1'b0;
  endtask

  // Driver for port B: active edge is the falling edge, controls active low.
  task automatic op_b(input logic en, input logic we, input logic rst,
                      input logic [AWB-1:0] ad, input logic [WB-1:0] d, input string tag);
    @(posedge clk_b);
    en_b = ~en; we_b = ~we; rst_b = ~rst; addr_b = ad; din_b = d;
    @(negedge clk_b);
    #1;
    if (en) begin
      if (rst) hold_b = '0;
      else if (we) hold_b = d;
      else hold_b = mdl[ad*WB +: WB];
      if (we) mdl[ad*WB +: WB] = d;
    end
    qb_val.push_back(hold_b);
    qb_tag.push_back(tag);
    en_b = 1'b1; we_b = 1'b1; rst_b = 1'b1;
  endtask

  // Monitors: compare one result per active edge, half a period later.
  always @(negedge clk_a) begin
    if (qa_val.size() > 0) begin
      logic [WA-1:0] e;
      string t;
      e = qa_val.pop_front();
      t = qa_tag.pop_front();
      check(t, 16'(dout_a), 16'(e));
    end
  end

  always @(posedge clk_b) begin
    if (qb_val.size() > 0) begin
      logic [WB-1:0] e;
      string t;
      e = qb_val.pop_front();
      t = qb_tag.pop_front();
      check(t, 16'(dout_b), 16'(e));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check("R10 dout_a at start", 16'(dout_a), 16'h0);
    check("R10 dout_b at start", 16'(dout_b), 16'h0);
    op_a(1, 0, 0, 9'd5, 8'h00, "R10 A read zero array");
    op_b(1, 0, 0, 11'd100, 2'b00, "R10 B read zero array");

    op_a(1, 1, 0, 9'd3, 8'h3C, "R4 A write-first");
    op_a(1, 0, 0, 9'd3, 8'h00, "R3 A read back");
    for (int k = 12; k < 16; k++) op_b(1, 0, 0, AWB'(k), 2'b00, "R1 R9 B reads A byte");
    op_b(1, 1, 0, 11'd16, 2'b10, "R4 R8 B write-first");
    op_a(1, 0, 0, 9'd4, 8'h00, "R1 R9 A reads B pair");

    op_a(0, 1, 0, 9'd4, 8'hFF, "R5 A disabled holds");
    op_a(1, 0, 0, 9'd4, 8'h00, "R5 disabled write ignored");
    op_a(1, 0, 1, 9'd4, 8'h00, "R6 A clear");
    op_a(1, 0, 0, 9'd4, 8'h00, "R6 memory kept after clear");
    op_a(0, 0, 1, 9'd4, 8'h00, "R6 clear without enable");

    op_a(1, 1, 1, 9'd7, 8'hA5, "R7 clear with write");
    op_a(1, 0, 0, 9'd7, 8'h00, "R7 write stored");
    op_b(1, 0, 0, 11'd28, 2'b00, "R7 R1 B sees low pair");
    op_b(1, 0, 1, 11'd28, 2'b00, "R6 R8 B clear active-low");
    op_b(0, 1, 0, 11'd28, 2'b11, "R5 R8 B disabled holds");
    op_b(1, 0, 0, 11'd28, 2'b00, "R5 B disabled write ignored");

    op_a(1, 1, 0, 9'd511, 8'hC6, "R2 A top address");
    op_b(1, 0, 0, 11'd2047, 2'b00, "R2 B top address");
    op_b(1, 1, 0, 11'd2040, 2'b01, "R2 B write near top");
    op_a(1, 0, 0, 9'd510, 8'h00, "R2 A reads B near top");

    fork
      begin
        for (int k = 20; k < 30; k++) op_a(1, 1, 0, AWA'(k), 8'(k * 37 + 5), "R11 A write concurrent");
      end
      begin
        for (int k = 0; k < 12; k++) op_b(1, 0, (k % 3) == 0, AWB'(k), 2'b00, "R11 B clear/read concurrent");
        for (int k = 400; k < 410; k++) op_b(1, 1, 0, AWB'(k), 2'(k), "R9 B write concurrent");
      end
    join
    for (int k = 20; k < 30; k++) op_a(1, 0, 0, AWA'(k), 8'h00, "R11 A writes intact");
    for (int k = 400; k < 410; k++) op_b(1, 0, 0, AWB'(k), 2'b00, "R9 B writes intact");
    op_a(1, 0, 0, 9'd100, 8'h00, "R1 A reads B region");

    for (int i = 0; i < 300; i++) begin
      logic en, we, rst;
      en  = ($urandom % 5) != 0;
      we  = ($urandom % 2) == 1;
      rst = ($urandom % 10) == 0;
      if ($urandom % 2 == 1)
        op_a(en, we, rst, AWA'($urandom % 16), 8'($urandom), "R3 R4 random A");
      else
        op_b(en, we, rst, AWB'($urandom % 64), 2'($urandom), "R3 R4 random B");
    end

    repeat (3) @(negedge clk_a);
    repeat (3) @(posedge clk_b);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule